// File: doc/BRIEF.md
# Quadrant Target Handoff Controller

This block sits beside four tracking units, each of which owns one quadrant of a two-dimensional field. It watches the position estimates made by the unit that currently owns the single tracked target. It works out which quadrant each estimate falls in. When an estimate lands outside the owner's quadrant, the block captures the full filter state (x, y, vx, vy). It streams that state word by word through an asynchronous FIFO into the faster link clock domain. There the state is reassembled and offered as a load to the destination unit.

Ownership moves only after the destination acknowledges that it has loaded the state, so the target is never dropped. A handoff into a quadrant that already holds another target is refused: a conflict is signalled and the current owner keeps the target. The first estimate after any change of owner is never treated as a crossing. This stops a target sitting on a boundary from bouncing between units.

Top module: `hoff_top`

## Requirements
- R1: The quadrant of an estimate is a 2-bit index. Bit 0 is 1 when est_x >= bnd_x and bit 1 is 1 when est_y >= bnd_y, with both compared as signed two's complement numbers. Equality counts as the upper side.
- R2: After reset, own_vld, busy, conflict and ld_valid are all 0.
- R3: With no owner, the first accepted estimate makes its quadrant the owner (own_vld=1, own_q=quadrant) on the next proc clock edge, with no transfer.
- R4: An estimate whose quadrant equals own_q causes no transfer and no conflict, and leaves own_q unchanged.
- R5: When an armed owner gets an estimate in another quadrant q and occ_in[q]=0, busy rises on the next proc edge. ld_valid then rises in the link domain with ld_quad=q and ld_x, ld_y, ld_vx, ld_vy equal to that estimate.
- R6: While a handoff is pending, own_q keeps the source quadrant. It changes to the destination, and busy falls, only after ld_ack is given.
- R7: When an armed owner gets an estimate in another quadrant q with occ_in[q]=1, conflict is 1 for exactly one proc cycle. busy stays 0 and own_q is unchanged.
- R8: The first estimate after an ownership change (a claim or a completed handoff) never starts a handoff or raises a conflict, whatever its quadrant.
- R9: Estimates that arrive while busy=1 are ignored. They produce no conflict and no further load, and they do not change the final owner.
- R10: Once ld_valid is 1, it and the load fields stay unchanged until ld_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_proc | input | 1 | Tracking datapath clock |
| clk_link | input | 1 | Faster handoff link clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| bnd_x | input | W | Signed x boundary |
| bnd_y | input | W | Signed y boundary |
| est_valid | input | 1 | Owner's predict/correct cycle produced an estimate |
| est_x | input | W | Estimated x position |
| est_y | input | W | Estimated y position |
| est_vx | input | W | Estimated x velocity |
| est_vy | input | W | Estimated y velocity |
| occ_in | input | 4 | Quadrants already holding another target, one bit per quadrant index |
| own_vld | output | 1 | A quadrant owns the target |
| own_q | output | 2 | Owning quadrant index |
| busy | output | 1 | Handoff in progress |
| conflict | output | 1 | One-cycle pulse: handoff refused because the destination is occupied |
| ld_valid | output | 1 | Link domain: reassembled state offered to the destination |
| ld_quad | output | 2 | Link domain: destination quadrant |
| ld_x | output | W | Loaded x position |
| ld_y | output | W | Loaded y position |
| ld_vx | output | W | Loaded x velocity |
| ld_vy | output | W | Loaded y velocity |
| ld_ack | input | 1 | Link domain: destination has loaded the state |

## Verification
The hardest situation to reach is an estimate arriving while a handoff is in flight. At that moment the state is partly inside the FIFO or waiting on an acknowledge in the other clock domain. The bench reaches it by firing a stray estimate into a third, fully occupied quadrant as soon as busy rises. It then holds off ld_ack for many link cycles before acknowledging. The sweep covers every pair of source and destination quadrants, each with a free and an occupied destination. Boundary-equal coordinates are included, so the claim, hold-off, refusal and completed-transfer paths are each met from every quadrant.

// File: rtl/hoff_pkg.sv
package hoff_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_SEND  = 2'd2,
    ST_WAIT  = 2'd3
  } hoff_st_e;

  localparam int NUM_QUAD  = 4;
  localparam int NUM_WORDS = 4;

  function automatic logic [7:0] bin2gray(input logic [7:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [7:0] gray2bin(input logic [7:0] g);
    logic [7:0] b;
    b[7] = g[7];
    for (int i = 6; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction
endpackage

// File: rtl/hoff_rstsync.sv
module hoff_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= 2'b00;
    else        sh_q <= {sh_q[0], 1'b1};
  end

  assign rst_sync_n = sh_q[1];
endmodule

// File: rtl/hoff_quad.sv
module hoff_quad #(
  parameter int W = 16
) (
  input  logic signed [W-1:0] pos_x,
  input  logic signed [W-1:0] pos_y,
  input  logic signed [W-1:0] lim_x,
  input  logic signed [W-1:0] lim_y,
  output logic        [1:0]   quad
);
  always_comb begin
    quad[0] = (pos_x >= lim_x);
    quad[1] = (pos_y >= lim_y);
  end
endmodule

// File: rtl/hoff_afifo.sv
module hoff_afifo #(
  parameter int DW = 19,
  parameter int AW = 2
) (
  input  logic          wclk,
  input  logic          wrst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst_n,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          empty
);
  import hoff_pkg::*;
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wbin_q, wbin_d, wgray_q;
  logic [PW-1:0] rbin_q, rbin_d, rgray_q;
  logic [PW-1:0] rg_w1_q, rg_w2_q;
  logic [PW-1:0] wg_r1_q, wg_r2_q;
  logic          wr_fire, rd_fire;

  assign wr_fire = wr_en && !full;
  assign rd_fire = rd_en && !empty;

  always_comb begin
    wbin_d = wbin_q;
    if (wr_fire) wbin_d = wbin_q + 1'b1;
    rbin_d = rbin_q;
    if (rd_fire) rbin_d = rbin_q + 1'b1;
  end

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wbin_q[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk or negedge wrst_n) begin
    if (!wrst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      rg_w1_q <= '0;
      rg_w2_q <= '0;
    end else begin
      wbin_q  <= wbin_d;
      wgray_q <= PW'(bin2gray(8'(wbin_d)));
      rg_w1_q <= rgray_q;
      rg_w2_q <= rg_w1_q;
    end
  end

  always_ff @(posedge rclk or negedge rrst_n) begin
    if (!rrst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      wg_r1_q <= '0;
      wg_r2_q <= '0;
    end else begin
      rbin_q  <= rbin_d;
      rgray_q <= PW'(bin2gray(8'(rbin_d)));
      wg_r1_q <= wgray_q;
      wg_r2_q <= wg_r1_q;
    end
  end

  generate
    if (AW >= 2) begin : g_full_wide
      assign full = (wgray_q == {~rg_w2_q[PW-1:PW-2], rg_w2_q[PW-3:0]});
    end else begin : g_full_narrow
      assign full = (wgray_q == ~rg_w2_q);
    end
  endgenerate

  assign empty = (rgray_q == wg_r2_q);
  assign rdata = mem[rbin_q[AW-1:0]];

  logic [PW-1:0] rsync_bin, fill_w;
  assign rsync_bin = PW'(gray2bin(8'(rg_w2_q)));
  assign fill_w    = wbin_q - rsync_bin;

  assert_no_overflow_R5: assert property (@(posedge wclk) disable iff (!wrst_n)
    fill_w <= PW'(DEPTH));
  assert_no_underflow_R5: assert property (@(posedge rclk) disable iff (!rrst_n)
    empty |=> (rbin_q == $past(rbin_q)));
endmodule

// File: rtl/hoff_rx.sv
module hoff_rx #(
  parameter int W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                empty,
  input  logic [W+2:0]        rdata,
  output logic                rd_en,
  output logic                ld_valid,
  output logic [1:0]          ld_quad,
  output logic [3:0][W-1:0]   ld_state,
  input  logic                ld_ack,
  output logic                ack_tgl
);
  logic               vld_q, vld_d;
  logic [1:0]         quad_q, quad_d;
  logic [3:0][W-1:0]  st_q, st_d;
  logic [1:0]         cnt_q, cnt_d;
  logic               tgl_q, tgl_d;
  logic [1:0]         slot;

  assign rd_en = !empty && !vld_q;
  assign slot  = rdata[W+2] ? 2'd0 : cnt_q;

  always_comb begin
    vld_d  = vld_q;
    quad_d = quad_q;
    st_d   = st_q;
    cnt_d  = cnt_q;
    tgl_d  = tgl_q;
    if (rd_en) begin
      st_d[slot] = rdata[W-1:0];
      if (slot == 2'd3) begin
        vld_d  = 1'b1;
        quad_d = rdata[W+1:W];
        cnt_d  = 2'd0;
      end else begin
        cnt_d  = slot + 2'd1;
      end
    end
    if (vld_q && ld_ack) begin
      vld_d = 1'b0;
      tgl_d = ~tgl_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      quad_q <= 2'd0;
      st_q   <= '0;
      cnt_q  <= 2'd0;
      tgl_q  <= 1'b0;
    end else begin
      vld_q  <= vld_d;
      quad_q <= quad_d;
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      tgl_q  <= tgl_d;
    end
  end

  assign ld_valid = vld_q;
  assign ld_quad  = quad_q;
  assign ld_state = st_q;
  assign ack_tgl  = tgl_q;

  assert_load_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && !ld_ack) |=> (vld_q && $stable(st_q) && $stable(quad_q)));
  assert_no_read_while_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |=> (cnt_q == 2'd0));
endmodule

// File: rtl/hoff_top.sv
module hoff_top #(
  parameter int W  = 16,
  parameter int AW = 2
) (
  input  logic                clk_proc,
  input  logic                clk_link,
  input  logic                rst_n,
  input  logic signed [W-1:0] bnd_x,
  input  logic signed [W-1:0] bnd_y,
  input  logic                est_valid,
  input  logic signed [W-1:0] est_x,
  input  logic signed [W-1:0] est_y,
  input  logic signed [W-1:0] est_vx,
  input  logic signed [W-1:0] est_vy,
  input  logic [3:0]          occ_in,
  output logic                own_vld,
  output logic [1:0]          own_q,
  output logic                busy,
  output logic                conflict,
  output logic                ld_valid,
  output logic [1:0]          ld_quad,
  output logic [W-1:0]        ld_x,
  output logic [W-1:0]        ld_y,
  output logic [W-1:0]        ld_vx,
  output logic [W-1:0]        ld_vy,
  input  logic                ld_ack
);
  import hoff_pkg::*;
  localparam int FW = W + 3;

  logic rst_p_n, rst_l_n;
  hoff_rstsync i_rs_proc (.clk(clk_proc), .rst_n(rst_n), .rst_sync_n(rst_p_n));
  hoff_rstsync i_rs_link (.clk(clk_link), .rst_n(rst_n), .rst_sync_n(rst_l_n));

  logic [1:0] est_quad;
  hoff_quad #(.W(W)) i_quad (
    .pos_x(est_x), .pos_y(est_y), .lim_x(bnd_x), .lim_y(bnd_y), .quad(est_quad)
  );

  hoff_st_e          st_q, st_d;
  logic [1:0]        own_r, own_d, dest_q, dest_d, cnt_q, cnt_d;
  logic              ownv_q, ownv_d, armed_q, armed_d, conf_q, conf_d;
  logic [3:0][W-1:0] snap_q, snap_d;
  logic              wr_en, full, empty, rd_en, ack_tgl, ack_evt;
  logic [FW-1:0]     wr_word, rd_word;
  logic [2:0]        ack_sync_q;

  always_ff @(posedge clk_proc or negedge rst_p_n) begin
    if (!rst_p_n) ack_sync_q <= 3'b000;
    else          ack_sync_q <= {ack_sync_q[1:0], ack_tgl};
  end
  assign ack_evt = ack_sync_q[2] ^ ack_sync_q[1];

  always_comb begin
    st_d    = st_q;
    own_d   = own_r;
    ownv_d  = ownv_q;
    armed_d = armed_q;
    dest_d  = dest_q;
    cnt_d   = cnt_q;
    snap_d  = snap_q;
    conf_d  = 1'b0;
    wr_en   = 1'b0;
    wr_word = {(cnt_q == 2'd0), dest_q, snap_q[cnt_q]};
    unique case (st_q)
      ST_IDLE: begin
        if (est_valid) begin
          own_d   = est_quad;
          ownv_d  = 1'b1;
          armed_d = 1'b0;
          st_d    = ST_TRACK;
        end
      end
      ST_TRACK: begin
        if (est_valid) begin
          if (!armed_q) begin
            armed_d = 1'b1;
          end else if (est_quad != own_r) begin
            if (occ_in[est_quad]) begin
              conf_d = 1'b1;
            end else begin
              snap_d = {est_vy, est_vx, est_y, est_x};
              dest_d = est_quad;
              cnt_d  = 2'd0;
              st_d   = ST_SEND;
            end
          end
        end
      end
      ST_SEND: begin
        if (!full) begin
          wr_en = 1'b1;
          cnt_d = cnt_q + 2'd1;
          if (cnt_q == 2'd3) st_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (ack_evt) begin
          own_d   = dest_q;
          armed_d = 1'b0;
          st_d    = ST_TRACK;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_proc or negedge rst_p_n) begin
    if (!rst_p_n) begin
      st_q    <= ST_IDLE;
      own_r   <= 2'd0;
      ownv_q  <= 1'b0;
      armed_q <= 1'b0;
      dest_q  <= 2'd0;
      cnt_q   <= 2'd0;
      snap_q  <= '0;
      conf_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      own_r   <= own_d;
      ownv_q  <= ownv_d;
      armed_q <= armed_d;
      dest_q  <= dest_d;
      cnt_q   <= cnt_d;
      snap_q  <= snap_d;
      conf_q  <= conf_d;
    end
  end

  hoff_afifo #(.DW(FW), .AW(AW)) i_fifo (
    .wclk(clk_proc), .wrst_n(rst_p_n), .wr_en(wr_en), .wdata(wr_word), .full(full),
    .rclk(clk_link), .rrst_n(rst_l_n), .rd_en(rd_en), .rdata(rd_word), .empty(empty)
  );

  logic [3:0][W-1:0] ld_state;
  hoff_rx #(.W(W)) i_rx (
    .clk(clk_link), .rst_n(rst_l_n), .empty(empty), .rdata(rd_word), .rd_en(rd_en),
    .ld_valid(ld_valid), .ld_quad(ld_quad), .ld_state(ld_state),
    .ld_ack(ld_ack), .ack_tgl(ack_tgl)
  );

  assign ld_x     = ld_state[0];
  assign ld_y     = ld_state[1];
  assign ld_vx    = ld_state[2];
  assign ld_vy    = ld_state[3];
  assign own_vld  = ownv_q;
  assign own_q    = own_r;
  assign busy     = (st_q == ST_SEND) || (st_q == ST_WAIT);
  assign conflict = conf_q;

  assert_owner_hold_R6: assert property (@(posedge clk_proc) disable iff (!rst_p_n)
    (busy && !ack_evt) |=> $stable(own_r));
  assert_busy_has_owner_R5: assert property (@(posedge clk_proc) disable iff (!rst_p_n)
    busy |-> ownv_q);
  assert_conflict_no_send_R7: assert property (@(posedge clk_proc) disable iff (!rst_p_n)
    conf_q |-> (st_q == ST_TRACK));
  assert_dest_differs_R5: assert property (@(posedge clk_proc) disable iff (!rst_p_n)
    busy |-> (dest_q != own_r));
  assert_holdoff_R8: assert property (@(posedge clk_proc) disable iff (!rst_p_n)
    ($past(ack_evt) && $past(st_q == ST_WAIT)) |-> !armed_q);
endmodule

// File: tb/test_hoff_top.sv
module test_hoff_top;
  localparam int W = 16;

  logic clk_proc = 1'b0, clk_link = 1'b0, rst_n = 1'b0;
  logic signed [W-1:0] bnd_x, bnd_y, est_x, est_y, est_vx, est_vy;
  logic est_valid, ld_ack;
  logic [3:0] occ_in;
  logic own_vld, busy, conflict, ld_valid;
  logic [1:0] own_q, ld_quad;
  logic [W-1:0] ld_x, ld_y, ld_vx, ld_vy;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk_proc = ~clk_proc;
  always #1 clk_link = ~clk_link;

  hoff_top #(.W(W), .AW(2)) i_hoff_top (
    .clk_proc(clk_proc), .clk_link(clk_link), .rst_n(rst_n),
    .bnd_x(bnd_x), .bnd_y(bnd_y), .est_valid(est_valid),
    .est_x(est_x), .est_y(est_y), .est_vx(est_vx), .est_vy(est_vy),
    .occ_in(occ_in), .own_vld(own_vld), .own_q(own_q), .busy(busy),
    .conflict(conflict), .ld_valid(ld_valid), .ld_quad(ld_quad),
    .ld_x(ld_x), .ld_y(ld_y), .ld_vx(ld_vx), .ld_vy(ld_vy), .ld_ack(ld_ack)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic signed [W-1:0] px(input int q, input int k);
    return q[0] ? W'(bnd_x + k) : W'(bnd_x - 1 - k);
  endfunction
  function automatic logic signed [W-1:0] py(input int q, input int k);
    return q[1] ? W'(bnd_y + k) : W'(bnd_y - 1 - k);
  endfunction

  task automatic send_est(input int q, input int k, input int v);
    @(negedge clk_proc);
    est_valid = 1'b1;
    est_x = px(q, k); est_y = py(q, k);
    est_vx = W'(v); est_vy = W'(-v - 3);
    @(negedge clk_proc);
    est_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; est_valid = 1'b0; ld_ack = 1'b0; occ_in = 4'h0;
    repeat (3) @(negedge clk_proc);
    rst_n = 1'b1;
    repeat (4) @(negedge clk_proc);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bnd_x = 16'sd100; bnd_y = -16'sd50;
    est_x = '0; est_y = '0; est_vx = '0; est_vy = '0;
    do_reset();
    chk(!own_vld && !busy && !conflict && !ld_valid, "R2",
        {own_vld, busy, conflict, ld_valid}, 0);
    for (int src = 0; src < 4; src++) begin
      for (int dst = 0; dst < 4; dst++) begin
        for (int b = 0; b < 2; b++) begin
          int k, v, hold_q, waited;
          k = (src * 4 + dst + b) % 3;
          v = src * 40 + dst * 7 + b - 30;
          do_reset();
          // R3 claim
          send_est(src, k, v);
          chk(own_vld && own_q == 2'(src) && !busy, "R3", own_q, src);
          // R8 hold-off: first estimate after claim is in dst, no handoff
          send_est(dst, k + 1, v);
          occ_in = 4'hF;
          @(negedge clk_proc);
          chk(!busy && !conflict && own_q == 2'(src), "R8", busy, 0);
          // R1 boundary decode: same-quadrant estimate at the exact boundary is no crossing
          occ_in = 4'h0;
          send_est(src, 0, v);
          chk(!busy && !conflict && own_q == 2'(src), "R1", own_q, src);
          occ_in = b ? (4'h1 << dst) : 4'h0;
          send_est(dst, k, v);
          if (dst == src) begin
            chk(!busy && !conflict && own_q == 2'(src), "R4", own_q, src);
          end else if (b == 1) begin
            chk(conflict && !busy, "R7", conflict, 1);
            @(negedge clk_proc);
            chk(!conflict && !busy && own_q == 2'(src), "R7", conflict, 0);
          end else begin
            chk(busy, "R5", busy, 1);
            // R9 stray estimate during handoff
            hold_q = (src ^ 3) != dst ? (src ^ 3) : (src ^ 1);
            occ_in = 4'hF;
            send_est(hold_q, 1, 5);
            chk(!conflict, "R9", conflict, 0);
            occ_in = 4'h0;
            waited = 0;
            while (!ld_valid && waited < 200) begin @(negedge clk_link); waited++; end
            chk(ld_valid && ld_quad == 2'(dst), "R5", ld_quad, dst);
            chk(ld_x == px(dst, k) && ld_y == py(dst, k), "R5", ld_x, px(dst, k));
            chk(ld_vx == W'(v) && ld_vy == W'(-v - 3), "R5", ld_vx, v);
            repeat (20) @(negedge clk_link);
            chk(ld_valid && ld_x == px(dst, k) && ld_vy == W'(-v - 3), "R10", ld_valid, 1);
            chk(busy && own_q == 2'(src), "R6", own_q, src);
            ld_ack = 1'b1;
            @(negedge clk_link);
            ld_ack = 1'b0;
            waited = 0;
            while (busy && waited < 200) begin @(negedge clk_proc); waited++; end
            chk(!busy && own_q == 2'(dst), "R6", own_q, dst);
            repeat (10) @(negedge clk_proc);
            chk(!ld_valid && own_q == 2'(dst), "R9", ld_valid, 0);
            // R8 after handoff: estimate back in src is ignored as a crossing
            send_est(src, 2, v);
            chk(!busy && !conflict && own_q == 2'(dst), "R8", busy, 0);
          end
        end
      end
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule